// File: doc/BRIEF.md
# Per-Set Recency Stack with Selectable Fill Placement

This block keeps the recency order of the ways of one set in an N-way set-associative cache. It picks the victim for a miss and updates the order after each access. The order is held as a stack of way numbers. Position 0 is the most recently used (MRU) slot and position N-1 is the least recently used (LRU) slot. A hit pulls the referenced way to the top of the stack.

On a miss, the way in the bottom slot is offered as the victim. The placement input then sets where the refilled line goes in the stack:
- **Conventional placement:** the refilled line goes to the top of the stack.
- **Bottom-only placement:** the refilled line stays at the bottom of the stack.
- **Throttled placement:** most refilled lines stay at the bottom. About one in thirty-two goes to the top, so that resident lines still age.

A free-running linear feedback shift register makes the throttled choice. Tag compare and the data array belong to the surrounding cache.

The surrounding logic presents one access per cycle. Each access carries a hit flag, the hit way and the placement mode. The logic reads the victim combinationally from the current stack. The stack changes on the clock edge that samples the access, so the new order is visible in the next cycle.

Top module: `lru_ins_stack`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, position p of the stack holds way p. Position 0 holds way 0 and position N-1 holds way N-1.
- R2: `victimWay` always equals the way held at position N-1 of the current stack.
- R3: On a hit, the hit way moves to position 0. Each way that was above it moves down one position. Ways below it keep their positions.
- R4: On a miss with `insMode` 0 or 3 (conventional placement), the victim moves to position 0 and every other way moves down one position.
- R5: On a miss with `insMode` 1 (bottom-only placement), the stack is left unchanged.
- R6: A way left at position N-1 by a bottom-only fill moves to position 0 when a later hit references it.
- R7: On a miss with `insMode` 2 (throttled placement), the victim moves to position 0 only if the low 5 bits of the random register are all zero in that cycle. Otherwise the stack is unchanged.
- R8: The random register is 16 bits wide and loads 16'hACE1 on reset. Every clock after reset it becomes {s[14:0], parity(s & 16'hB400)}. It never holds zero.
- R9: In a cycle with `accessValid` low, the stack is unchanged.
- R10: The stack always holds each way exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accessValid | input | 1 | An access to this set occurs in this cycle |
| accessHit | input | 1 | 1 = hit on `hitWay`, 0 = miss |
| hitWay | input | WAY_W | Way that hit; ignored on a miss |
| insMode | input | 2 | Fill placement: 0 conventional, 1 bottom-only, 2 throttled, 3 conventional |
| victimWay | output | WAY_W | Way at the LRU position, to be replaced on a miss |
| orderFlat | output | NUM_WAYS*WAY_W | Stack contents; bits [p*WAY_W +: WAY_W] hold the way at position p |

## Verification
The assertions take two things for granted:
- `hitWay` names an existing way whenever a hit is presented.
- The hit flag matters only when `accessValid` is high.

If `hitWay` were out of range, the permutation property would not hold, because the searched way would not be found in the stack. The bench meets both conditions. It draws hit ways only from 0 to N-1 and drives the hit flag and mode randomly, with or without an access. This also shows that those inputs have no effect in idle cycles.

// File: rtl/lru_ins_pkg.sv
package lru_ins_pkg;

  // Fill placement selected per access.
  typedef enum logic [1:0] {
    INS_MRU     = 2'd0,
    INS_LRU     = 2'd1,
    INS_BIMODAL = 2'd2,
    INS_MRU_ALT = 2'd3
  } insMode_e;

  // Strobes from control to the stack datapath.
  typedef struct packed {
    logic promote;  // rewrite the stack this cycle
    logic fromHit;  // moved way is the hit way (else the victim)
  } stackStrobes_t;

endpackage

// File: rtl/lru_throttle_lfsr.sv
module lru_throttle_lfsr #(
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
  parameter int                LOW_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [LOW_W-1:0] lowBits
);

  logic [LFSR_W-1:0] state;
  logic              feedback;

  assign feedback = ^(state & TAPS);
  assign lowBits  = state[LOW_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else       state <= {state[LFSR_W-2:0], feedback};
  end

  // R8: register never collapses to the all-zero lock-up state
  a_r8_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

  // R8: shifts left by one every cycle after reset
  a_r8_shift: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> state[LFSR_W-1:1] == $past(state[LFSR_W-2:0]));

endmodule

// File: rtl/lru_ins_ctrl.sv
module lru_ins_ctrl
  import lru_ins_pkg::*;
#(
  parameter int LOW_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accessValid,
  input  logic             accessHit,
  input  logic [1:0]       insMode,
  input  logic [LOW_W-1:0] lfsrLow,
  output stackStrobes_t    strobes
);

  insMode_e mode;
  logic     throttleHit;
  logic     placeMru;

  assign mode        = insMode_e'(insMode);
  assign throttleHit = (lfsrLow == '0);

  always_comb begin
    placeMru = 1'b0;
    unique case (mode)
      INS_MRU, INS_MRU_ALT: placeMru = 1'b1;
      INS_LRU:              placeMru = 1'b0;
      INS_BIMODAL:          placeMru = throttleHit;
      default:              placeMru = 1'b1;
    endcase
  end

  always_comb begin
    strobes.promote = accessValid & (accessHit | placeMru);
    strobes.fromHit = accessHit;
  end

  // R5: bottom-only fill never rewrites the stack
  a_r5_lru_fill_no_promote: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && !accessHit && insMode == 2'd1) |-> !strobes.promote);

  // R4: conventional fill always promotes the victim
  a_r4_mru_fill_promotes: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && !accessHit && (insMode == 2'd0 || insMode == 2'd3))
      |-> (strobes.promote && !strobes.fromHit));

  // R7: throttled fill promotes only on an all-zero random draw
  a_r7_throttle_gate: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && !accessHit && insMode == 2'd2 && lfsrLow != '0) |-> !strobes.promote);

  // R9: no access, no rewrite
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accessValid |-> !strobes.promote);

endmodule

// File: rtl/lru_stack_dp.sv
module lru_stack_dp
  import lru_ins_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stackStrobes_t             strobes,
  input  logic [WAY_W-1:0]          hitWay,
  output logic [WAY_W-1:0]          victimWay,
  output logic [NUM_WAYS*WAY_W-1:0] orderFlat
);

  localparam int LAST = NUM_WAYS - 1;

  logic [WAY_W-1:0]    order     [NUM_WAYS];
  logic [WAY_W-1:0]    nextOrder [NUM_WAYS];
  logic [WAY_W-1:0]    selWay;
  logic [NUM_WAYS-1:0] matchVec;
  logic [NUM_WAYS-1:0] shiftVec;   // shiftVec[p]: selected way sits at p or below
  logic                selFound;

  assign victimWay = order[LAST];
  assign selWay    = strobes.fromHit ? hitWay : victimWay;
  assign selFound  = shiftVec[0];

  assign shiftVec[LAST] = matchVec[LAST];
  assign nextOrder[0]   = selWay;

  for (genvar p = 0; p < NUM_WAYS; p++) begin : g_pos
    assign matchVec[p] = (order[p] == selWay);
    assign orderFlat[p*WAY_W +: WAY_W] = order[p];
    if (p < LAST) begin : g_chain
      assign shiftVec[p] = matchVec[p] | shiftVec[p+1];
    end
    if (p > 0) begin : g_next
      assign nextOrder[p] = shiftVec[p] ? order[p-1] : order[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_WAYS; p++) order[p] <= WAY_W'(p);
    end else if (strobes.promote) begin
      for (int p = 0; p < NUM_WAYS; p++) order[p] <= nextOrder[p];
    end
  end

  // R10: every way held exactly once
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_perm
    logic [NUM_WAYS-1:0] seenAt;
    for (genvar p = 0; p < NUM_WAYS; p++) begin : g_seen
      assign seenAt[p] = (order[p] == WAY_W'(w));
    end
    a_r10_once: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(seenAt));
  end

  // R10: the way to be moved is always present
  a_r10_sel_found: assert property (@(posedge clk) disable iff (!rstN)
    strobes.promote |-> selFound);

  // R3: hit way appears at the top next cycle
  a_r3_hit_to_top: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.promote && strobes.fromHit) |=> order[0] == $past(hitWay));

  // R4: promoted victim appears at the top, old second-to-last becomes LRU
  a_r4_fill_to_top: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.promote && !strobes.fromHit) |=>
      (order[0] == $past(order[LAST]) && order[LAST] == $past(order[LAST-1])));

  // R9 / R5: no promote leaves the stack intact
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.promote |=> $stable(orderFlat));

endmodule

// File: rtl/lru_ins_stack.sv
module lru_ins_stack
  import lru_ins_pkg::*;
#(
  parameter int                NUM_WAYS  = 8,
  parameter int                WAY_W     = $clog2(NUM_WAYS),
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int                THROTTLE_BITS = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      accessValid,
  input  logic                      accessHit,
  input  logic [WAY_W-1:0]          hitWay,
  input  logic [1:0]                insMode,
  output logic [WAY_W-1:0]          victimWay,
  output logic [NUM_WAYS*WAY_W-1:0] orderFlat
);

  logic [THROTTLE_BITS-1:0] lfsrLow;
  stackStrobes_t            strobes;

  lru_throttle_lfsr #(
    .LFSR_W (LFSR_W),
    .TAPS   (LFSR_TAPS),
    .SEED   (LFSR_SEED),
    .LOW_W  (THROTTLE_BITS)
  ) i_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .lowBits (lfsrLow)
  );

  lru_ins_ctrl #(
    .LOW_W (THROTTLE_BITS)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .accessValid (accessValid),
    .accessHit   (accessHit),
    .insMode     (insMode),
    .lfsrLow     (lfsrLow),
    .strobes     (strobes)
  );

  lru_stack_dp #(
    .NUM_WAYS (NUM_WAYS),
    .WAY_W    (WAY_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hitWay    (hitWay),
    .victimWay (victimWay),
    .orderFlat (orderFlat)
  );

endmodule

// File: tb/test_lru_ins_stack.sv
module test_lru_ins_stack;

  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         accessValid = 1'b0;
  logic         accessHit = 1'b0;
  logic [W-1:0] hitWay = '0;
  logic [1:0]   insMode = 2'd0;
  logic [W-1:0] victimWay;
  logic [N*W-1:0] orderFlat;

  int checks = 0;
  int errors = 0;
  int throttledTop = 0;
  int throttledStay = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  int       mOrder[$];
  bit [15:0] mLfsr;
  string    lastTag = "R1";

  always #5ns clk = ~clk;

  lru_ins_stack i_lru_ins_stack (
    .clk(clk), .rstN(rstN), .accessValid(accessValid), .accessHit(accessHit),
    .hitWay(hitWay), .insMode(insMode), .victimWay(victimWay), .orderFlat(orderFlat)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void moveTop(int way);
    for (int i = 0; i < mOrder.size(); i++)
      if (mOrder[i] == way) begin
        mOrder.delete(i);
        break;
      end
    mOrder.push_front(way);
  endfunction

  // Reference model, updated at the same edge as the design.
  always @(posedge clk) begin
    if (!rstN) begin
      mOrder.delete();
      for (int i = 0; i < N; i++) mOrder.push_back(i);
      mLfsr   = 16'hACE1;
      lastTag = "R1";
    end else begin
      if (!accessValid) lastTag = "R9";
      else if (accessHit) begin
        moveTop(int'(hitWay));
        lastTag = "R3";
      end else begin
        case (insMode)
          2'd1: lastTag = "R5";
          2'd2: begin
            lastTag = "R7";
            if (mLfsr[4:0] == 5'd0) begin
              moveTop(mOrder[N-1]);
              throttledTop++;
            end else throttledStay++;
          end
          default: begin
            moveTop(mOrder[N-1]);
            lastTag = "R4";
          end
        endcase
      end
      mLfsr = {mLfsr[14:0], ^(mLfsr & 16'hB400)};
    end
    started = 1'b1;
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (started && !finished) begin
      int seen[N];
      bit perm;
      for (int p = 0; p < N; p++)
        check(int'(orderFlat[p*W +: W]) == mOrder[p], lastTag,
              int'(orderFlat[p*W +: W]), mOrder[p]);
      check(int'(victimWay) == mOrder[N-1], "R2", int'(victimWay), mOrder[N-1]);
      for (int w = 0; w < N; w++) seen[w] = 0;
      for (int p = 0; p < N; p++) seen[orderFlat[p*W +: W]]++;
      perm = 1'b1;
      for (int w = 0; w < N; w++) if (seen[w] != 1) perm = 1'b0;
      check(perm, "R10", int'(perm), 1);
    end
  end

  task automatic op(input bit v, input bit h, input int way, input int mode);
    accessValid = v;
    accessHit   = h;
    hitWay      = W'(way);
    insMode     = 2'(mode);
    @(negedge clk);
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset order
    for (int p = 0; p < N; p++)
      check(int'(orderFlat[p*W +: W]) == p, "R1", int'(orderFlat[p*W +: W]), p);
    rstN = 1'b1;
    @(negedge clk);
    // R3: hits at several depths
    op(1, 1, 5, 0);
    op(1, 1, 0, 1);
    op(1, 1, 7, 2);
    op(1, 1, 3, 0);
    // R4: conventional fills, both encodings
    op(1, 0, 0, 0);
    op(1, 0, 0, 3);
    op(1, 0, 0, 0);
    // R5: bottom-only fills, hitWay ignored
    op(1, 0, 2, 1);
    op(1, 0, 6, 1);
    // R9: idle cycles with junk on other inputs
    op(0, 1, 4, 0);
    op(0, 0, 1, 3);
    // R6: bottom-only fill then a hit on that way
    begin
      int v;
      op(1, 0, 0, 1);
      v = int'(victimWay);
      check(int'(orderFlat[N*W-1 -: W]) == v, "R6", int'(orderFlat[N*W-1 -: W]), v);
      op(1, 1, v, 1);
      check(int'(orderFlat[W-1:0]) == v, "R6", int'(orderFlat[W-1:0]), v);
    end
    // R7 / R8: long run of throttled fills
    for (int i = 0; i < 600; i++) op(1, 0, 0, 2);
    check(throttledTop > 0, "R7", throttledTop, 1);
    check(throttledStay > throttledTop, "R7", throttledStay, throttledTop);
    // Mixed random traffic
    for (int i = 0; i < 3000; i++)
      op(($urandom % 4) != 0, $urandom % 2, $urandom % N, $urandom % 4);
    // Reset mid-run returns to the initial order and seed (R1, R8)
    rstN = 1'b0;
    @(negedge clk);
    for (int p = 0; p < N; p++)
      check(int'(orderFlat[p*W +: W]) == p, "R1", int'(orderFlat[p*W +: W]), p);
    rstN = 1'b1;
    for (int i = 0; i < 200; i++) op(1, $urandom % 2, $urandom % N, 2);
    op(0, 0, 0, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule